// File: doc/BRIEF.md
# Programmable-Range Up-Counter

This block is a synchronous binary up-counter whose cycle is bounded by two programmable values: a restart value and a stop value. While counting is enabled it advances by one each rising clock edge; on the enabled edge where the count sits on the stop value it jumps back to the restart value instead of incrementing. The count also jumps back to the restart value from the all-ones state. As a result, a restart value above the stop value gives a cycle from the restart value up to all-ones. The counter can never lock up in a state outside its programmed range.

A synchronous clear and a synchronous parallel load override counting. Clear has the highest priority, then load, then the range jump, then the increment. A combinational terminal-count output is high while counting is enabled and the count is on the stop value or on all-ones. That output can drive the count enable of a following stage to build wider chains, or tell a controller that a pass through the range has finished.

The block moves no data stream, so it has no valid/ready handshake. Every pin is a plain level-sensitive control or status signal sampled on the rising edge, and there is no back-pressure to observe.

Top module: `offset_counter`

## Requirements
- R1: When `clr` is high at a rising edge, `count` is 0 after that edge, whatever `ld`, `cnt_en` and the range inputs are.
- R2: When `clr` is low and `ld` is high at a rising edge, `count` equals `ld_val` after that edge, regardless of `cnt_en` and of whether the count was on the stop value or all-ones.
- R3: When `clr`, `ld` and `cnt_en` are all low at a rising edge, `count` keeps its value.
- R4: When only `cnt_en` is high among the controls and `count` is neither `range_hi` nor all-ones, `count` becomes `count + 1` after the edge.
- R5: When only `cnt_en` is high and `count` equals `range_hi`, `count` becomes `range_lo` after the edge. This includes the case `range_lo == range_hi`, where the count stays put.
- R6: When only `cnt_en` is high and `count` is all-ones (4'b1111 at the default width), `count` becomes `range_lo` after the edge. This is the wrap taken when `range_lo > range_hi` or when a load placed the count above `range_hi`.
- R7: `term` is high in the same cycle exactly when `cnt_en` is high and `count` equals `range_hi` or all-ones. With `cnt_en` low, `term` is low.
- R8: `term` depends only on `cnt_en`, `count` and `range_hi`. A high `clr` or `ld` does not suppress it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Synchronous clear to zero, highest priority |
| ld | input | 1 | Synchronous parallel load |
| ld_val | input | W | Value taken by a load |
| cnt_en | input | 1 | Count enable; also gates `term` |
| range_lo | input | W | Restart value taken after the stop value or all-ones |
| range_hi | input | W | Stop value on which the count jumps back |
| count | output | W | Current count |
| term | output | 1 | Terminal count: enabled and at stop value or all-ones |

## Verification
Several actions can land on the same edge: a load while the count sits on the stop value or all-ones with counting enabled, and a clear together with a load and an enable. The bench drives these coincidences on purpose. It first puts the count at the stop value or at 1111, then raises load or clear in that same cycle. It judges the outcome by checking that the higher-priority action alone sets the next count. In that same cycle it checks that `term` stayed high, because neither override masks it.

// File: rtl/oc_pkg.sv
package oc_pkg;
  // Action chosen for the next rising edge, already priority-resolved.
  typedef enum logic [2:0] {
    OC_HOLD  = 3'd0,
    OC_CLEAR = 3'd1,
    OC_LOAD  = 3'd2,
    OC_WRAP  = 3'd3,
    OC_STEP  = 3'd4
  } oc_act_e;
endpackage

// File: rtl/oc_match.sv
module oc_match #(
  parameter int W = 4
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] limit,
  output logic         at_limit,
  output logic         at_top
);
  logic [W-1:0] same_bit;

  // Per-bit equality, reduced by one AND tree.
  for (genvar g = 0; g < W; g++) begin : g_eq
    assign same_bit[g] = ~(cur[g] ^ limit[g]);
  end

  assign at_limit = &same_bit;
  assign at_top   = &cur;
endmodule

// File: rtl/oc_ctrl.sv
module oc_ctrl
  import oc_pkg::*;
(
  input  logic    clr,
  input  logic    ld,
  input  logic    en,
  input  logic    at_limit,
  input  logic    at_top,
  output oc_act_e act
);
  always_comb begin
    if (clr)                       act = OC_CLEAR;
    else if (ld)                   act = OC_LOAD;
    else if (!en)                  act = OC_HOLD;
    else if (at_limit || at_top)   act = OC_WRAP;
    else                           act = OC_STEP;
  end
endmodule

// File: rtl/oc_state.sv
module oc_state
  import oc_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  oc_act_e      act,
  input  logic [W-1:0] ld_val,
  input  logic [W-1:0] restart,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk) begin
    case (act)
      OC_CLEAR: q <= '0;
      OC_LOAD:  q <= ld_val;
      OC_WRAP:  q <= restart;
      OC_STEP:  q <= q + ONE;
      default:  q <= q;
    endcase
  end
endmodule

// File: rtl/offset_counter.sv
module offset_counter
  import oc_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         cnt_en,
  input  logic [W-1:0] range_lo,
  input  logic [W-1:0] range_hi,
  output logic [W-1:0] count,
  output logic         term
);
  logic    hit_hi;
  logic    hit_top;
  oc_act_e next_act;

  oc_match #(.W(W)) u_match (
    .cur      (count),
    .limit    (range_hi),
    .at_limit (hit_hi),
    .at_top   (hit_top)
  );

  oc_ctrl u_ctrl (
    .clr      (clr),
    .ld       (ld),
    .en       (cnt_en),
    .at_limit (hit_hi),
    .at_top   (hit_top),
    .act      (next_act)
  );

  oc_state #(.W(W)) u_state (
    .clk     (clk),
    .act     (next_act),
    .ld_val  (ld_val),
    .restart (range_lo),
    .q       (count)
  );

  // Terminal count: gated by enable only, never by clear or load.
  assign term = cnt_en & (hit_hi | hit_top);
endmodule

// File: rtl/oc_chk.sv
module oc_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         clr,
  input logic         ld,
  input logic [W-1:0] ld_val,
  input logic         cnt_en,
  input logic [W-1:0] range_lo,
  input logic [W-1:0] range_hi,
  input logic [W-1:0] count,
  input logic         term
);
  localparam logic [W-1:0] ALL1 = '1;

  // Checks are live only once a clear has defined the count.
  logic armed = 1'b0;
  always_ff @(posedge clk) if (clr) armed <= 1'b1;

  // R1
  clear_zero_chk: assert property (@(posedge clk) disable iff (!armed)
    clr |=> count == '0);

  // R2
  load_take_chk: assert property (@(posedge clk) disable iff (!armed)
    (!clr && ld) |=> count == $past(ld_val));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!armed)
    (!clr && !ld && !cnt_en) |=> $stable(count));

  // R4
  step_up_chk: assert property (@(posedge clk) disable iff (!armed)
    (!clr && !ld && cnt_en && count != range_hi && count != ALL1)
      |=> count == $past(count) + W'(1));

  // R5
  stop_wrap_chk: assert property (@(posedge clk) disable iff (!armed)
    (!clr && !ld && cnt_en && count == range_hi) |=> count == $past(range_lo));

  // R6
  top_wrap_chk: assert property (@(posedge clk) disable iff (!armed)
    (!clr && !ld && cnt_en && count == ALL1) |=> count == $past(range_lo));

  // R7
  term_gate_chk: assert property (@(posedge clk) disable iff (!armed)
    term |-> (cnt_en && (count == range_hi || count == ALL1)));

  // R8
  term_kept_chk: assert property (@(posedge clk) disable iff (!armed)
    (cnt_en && (clr || ld) && count == ALL1) |-> term);
endmodule

bind offset_counter oc_chk #(.W(W)) u_chk (.*);

// File: tb/test_offset_counter.sv
`timescale 1ns/1ps
module test_offset_counter;
  logic       clk = 1'b0;
  logic       clr = 1'b1;
  logic       ld = 1'b0;
  logic [3:0] ld_val = '0;
  logic       cnt_en = 1'b0;
  logic [3:0] range_lo = '0;
  logic [3:0] range_hi = '0;
  logic [3:0] count;
  logic       term;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  offset_counter #(.W(4)) i_offset_counter (
    .clk(clk), .clr(clr), .ld(ld), .ld_val(ld_val), .cnt_en(cnt_en),
    .range_lo(range_lo), .range_hi(range_hi), .count(count), .term(term)
  );

  // Vector: clr ld ldv[4] en lo[4] hi[4] term_exp nxt_exp[4]
  function automatic logic [19:0] mk(logic c, logic l, logic [3:0] lv, logic e,
                                     logic [3:0] lo, logic [3:0] hi,
                                     logic t, logic [3:0] nx);
    return {c, l, lv, e, lo, hi, t, nx};
  endfunction

  localparam int NV = 25;
  localparam logic [19:0] VEC [NV] = '{
    mk(0,0,4'h0,1,4'h0,4'h3,0,4'h1), // R4 from 0
    mk(0,0,4'h0,1,4'h0,4'h3,0,4'h2), // R4
    mk(0,0,4'h0,1,4'h0,4'h3,0,4'h3), // R4
    mk(0,0,4'h0,1,4'h0,4'h3,1,4'h0), // R5 R7 stop value
    mk(0,0,4'h0,0,4'h0,4'h3,0,4'h0), // R3 hold
    mk(0,0,4'h0,0,4'h0,4'h0,0,4'h0), // R7 at stop but disabled
    mk(0,1,4'hC,1,4'h6,4'hD,0,4'hC), // R2 load
    mk(0,0,4'h0,1,4'h6,4'hD,0,4'hD), // R4
    mk(0,0,4'h0,1,4'h6,4'hD,1,4'h6), // R5 restart offset
    mk(0,1,4'hE,1,4'h6,4'hD,0,4'hE), // R2 load above stop
    mk(0,0,4'h0,1,4'h6,4'hD,0,4'hF), // R4 past stop
    mk(0,0,4'h0,1,4'h6,4'hD,1,4'h6), // R6 all-ones wrap
    mk(0,1,4'h9,0,4'hA,4'h3,0,4'h9), // R2 load with enable low
    mk(0,0,4'h0,1,4'hA,4'h3,0,4'hA), // R4 lo above hi
    mk(0,1,4'hE,1,4'hA,4'h3,0,4'hE), // R2
    mk(0,0,4'h0,1,4'hA,4'h3,0,4'hF), // R4
    mk(0,0,4'h0,1,4'hA,4'h3,1,4'hA), // R6 lo above hi
    mk(1,1,4'h5,1,4'hA,4'hA,1,4'h0), // R1 R8 clear beats load and wrap
    mk(0,1,4'hF,0,4'h2,4'h5,0,4'hF), // R2
    mk(1,0,4'h0,0,4'h2,4'h5,0,4'h0), // R1 R7 disabled at all-ones
    mk(0,1,4'hF,1,4'h2,4'h5,0,4'hF), // R2
    mk(0,1,4'h3,1,4'h2,4'h5,1,4'h3), // R2 R8 load beats all-ones wrap
    mk(0,0,4'h0,1,4'h2,4'h3,1,4'h2), // R5
    mk(0,0,4'h0,1,4'h2,4'h2,1,4'h2), // R5 lo equals hi
    mk(0,0,4'h0,0,4'h2,4'h2,0,4'h2)  // R3 R7
  };

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    // Reset state (R1)
    @(posedge clk); #1;
    check("R1 reset", count, 4'h0);
    @(negedge clk); clr = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [19:0] v;
      v = VEC[i];
      @(negedge clk);
      clr = v[19]; ld = v[18]; ld_val = v[17:14]; cnt_en = v[13];
      range_lo = v[12:9]; range_hi = v[8:5];
      #1 check($sformatf("R7/R8 term vec%0d", i), {3'b0, term}, {3'b0, v[4]});
      @(posedge clk); #1;
      check($sformatf("R1-R6 count vec%0d", i), count, v[3:0]);
    end

    // Long idle hold (R3)
    @(negedge clk); clr = 0; ld = 1; ld_val = 4'h7; cnt_en = 0;
    @(negedge clk); ld = 0;
    for (int k = 0; k < 6; k++) @(negedge clk);
    check("R3 long hold", count, 4'h7);

    // Full natural run 0..F with range_hi=F, range_lo=0 (R4 R6)
    clr = 1; @(negedge clk); clr = 0;
    range_lo = 4'h0; range_hi = 4'hF; cnt_en = 1;
    for (int k = 1; k <= 16; k++) begin
      @(negedge clk);
      check("R4/R6 run", count, 4'(k));
    end
    cnt_en = 0;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule